// File: doc/BRIEF.md
# Double-Buffered PWM Generator

This block produces one pulse-width-modulated output from a counter that runs freely against a programmable period. A compare value sets how many clocks of each period the output spends in its active level, and a polarity control chooses whether that active level is high or low. Software reaches the block through a small word-wide register port. Writes are synchronous and reads are combinational.

Each of the period and compare values has two copies: an active one that the counter and comparator use, and a shadow one that software loads while the output is running. A shadow write arms a transfer. At the last clock of the period in progress, the pair is copied into the active registers, so a running waveform never shows a truncated or stretched cycle. While the counter is stopped, software may instead load the active pair directly and see the effect on the next clock.

Top module: `pwm_shadow_gen`

## Requirements
- R1: After reset, every register reads zero, the counter sits at zero and `pwm_out` is low.
- R2: The register addresses are 0 control (16 bits; upper write bits are discarded), 1 active period, 2 active compare, 3 shadow period and 4 shadow compare (32 bits each). Addresses 5 to 7 read zero. A read returns the current contents of the selected register on the same cycle.
- R3: Control bit 9 enables the PWM output. When bit 9 is clear, `pwm_out` is low regardless of counter and compare. Bits 7 and 6 (sync disable) are stored and read back.
- R4: Control bit 4 runs the counter. While bit 4 is clear, the counter holds its value.
- R5: While running, the counter steps by one per clock from 0 to P-1 and then wraps to 0, where P is the active period. A period of 0 behaves as a period of 1.
- R6: With control bit 10 clear, `pwm_out` is high while counter < compare and low otherwise. So compare 0 gives a constant low, and compare >= P gives a constant high.
- R7: With control bit 10 set, `pwm_out` is the complement of the R6 level, so the compare value sets the low time.
- R8: A write to either shadow register arms a transfer. On the wrap clock of a running counter with a transfer armed, both shadow values are copied into the active pair and the arm is cleared. The period in progress is unaffected.
- R9: Writes to the active period or compare registers take effect on the next clock when control bit 4 is clear, and are ignored while it is set.
- R10: A register write lands on the rising edge on which `reg_wr` is sampled high. A control write changes the output behaviour from the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 3 | Write address |
| reg_wdata | input | 32 | Write data |
| reg_raddr | input | 3 | Read address |
| reg_rdata | output | 32 | Read data for `reg_raddr` |
| pwm_out | output | 1 | PWM output |

## Verification
A wrong counter value or a wrongly timed shadow transfer shows on `pwm_out` within one period as a shifted edge or a high run of the wrong length. A bad active register shows on the read port on the very next cycle. The bench follows a cycle-level model built from the requirements and compares the output and a randomly addressed read every cycle. An error is therefore reported on the first clock where it becomes visible, including the clock just after an on-the-fly period change or a polarity flip.

// File: rtl/pwm_shadow_pkg.sv
package pwm_shadow_pkg;
  typedef enum logic [2:0] {
    REG_CTRL = 3'd0,
    REG_APER = 3'd1,
    REG_ACMP = 3'd2,
    REG_SPER = 3'd3,
    REG_SCMP = 3'd4
  } reg_sel_e;

  localparam int BIT_RUN   = 4;
  localparam int BIT_SYNC0 = 6;
  localparam int BIT_SYNC1 = 7;
  localparam int BIT_MODE  = 9;
  localparam int BIT_INV   = 10;
endpackage

// File: rtl/pwm_shadow_regs.sv
module pwm_shadow_regs
  import pwm_shadow_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CTRL_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [2:0]        raddr,
  output logic [DATA_W-1:0] rdata,
  input  logic              wrap,
  output logic [CTRL_W-1:0] ctrl,
  output logic [DATA_W-1:0] act_per,
  output logic [DATA_W-1:0] act_cmp
);
  localparam int PAD_W = DATA_W - CTRL_W;

  logic [CTRL_W-1:0] ctrl_q, ctrl_n;
  logic [DATA_W-1:0] aper_q, aper_n, acmp_q, acmp_n;
  logic [DATA_W-1:0] sper_q, sper_n, scmp_q, scmp_n;
  logic              pend_q, pend_n;
  logic              run, xfer, shadow_wr;

  always_comb begin
    run       = ctrl_q[BIT_RUN];
    xfer      = wrap & pend_q;
    shadow_wr = wr_en & ((waddr == REG_SPER) | (waddr == REG_SCMP));
    ctrl_n = ctrl_q;
    aper_n = aper_q;
    acmp_n = acmp_q;
    sper_n = sper_q;
    scmp_n = scmp_q;
    if (wr_en) begin
      case (waddr)
        REG_CTRL: ctrl_n = wdata[CTRL_W-1:0];
        REG_APER: if (!run) aper_n = wdata;
        REG_ACMP: if (!run) acmp_n = wdata;
        REG_SPER: sper_n = wdata;
        REG_SCMP: scmp_n = wdata;
        default:  ;
      endcase
    end
    if (xfer) begin
      aper_n = sper_q;
      acmp_n = scmp_q;
    end
    pend_n = (pend_q & ~xfer) | shadow_wr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      aper_q <= '0;
      acmp_q <= '0;
      sper_q <= '0;
      scmp_q <= '0;
      pend_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_n;
      aper_q <= aper_n;
      acmp_q <= acmp_n;
      sper_q <= sper_n;
      scmp_q <= scmp_n;
      pend_q <= pend_n;
    end
  end

  always_comb begin
    case (raddr)
      REG_CTRL: rdata = {{PAD_W{1'b0}}, ctrl_q};
      REG_APER: rdata = aper_q;
      REG_ACMP: rdata = acmp_q;
      REG_SPER: rdata = sper_q;
      REG_SCMP: rdata = scmp_q;
      default:  rdata = '0;
    endcase
  end

  assign ctrl    = ctrl_q;
  assign act_per = aper_q;
  assign act_cmp = acmp_q;

  // R9
  active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[BIT_RUN] && !wrap) |=> ($stable(aper_q) && $stable(acmp_q)));

  // R8
  xfer_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && pend_q) |=> (aper_q == $past(sper_q) && acmp_q == $past(scmp_q)));
endmodule

// File: rtl/pwm_shadow_counter.sv
module pwm_shadow_counter #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [DATA_W-1:0] period,
  output logic [DATA_W-1:0] cnt,
  output logic              wrap
);
  logic [DATA_W-1:0] cnt_q, cnt_n, last;

  always_comb begin
    last  = (period == '0) ? '0 : period - 1'b1;
    wrap  = run & (cnt_q >= last);
    cnt_n = cnt_q;
    if (run) cnt_n = wrap ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign cnt = cnt_q;

  // R4
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(cnt_q));

  // R5
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> (cnt_q == '0 || cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/pwm_shadow_compare.sv
module pwm_shadow_compare #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] cnt,
  input  logic [DATA_W-1:0] cmp,
  input  logic              mode,
  input  logic              inv,
  output logic              pwm
);
  logic active;

  always_comb begin
    active = cnt < cmp;
    pwm    = mode & (active ^ inv);
  end

  // R6
  fall_at_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode && !inv && $past(mode) && !$past(inv) && $stable(cmp) && $fell(pwm))
      |-> (cnt == cmp));
endmodule

// File: rtl/pwm_shadow_gen.sv
module pwm_shadow_gen
  import pwm_shadow_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CTRL_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_waddr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [2:0]        reg_raddr,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              pwm_out
);
  logic [1:0]        rst_sync;
  logic              core_rst_n;
  logic [CTRL_W-1:0] ctrl;
  logic [DATA_W-1:0] act_per, act_cmp, cnt;
  logic              wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign core_rst_n = rst_sync[1];

  pwm_shadow_regs #(.DATA_W(DATA_W), .CTRL_W(CTRL_W)) u_regs (
    .clk(clk), .rst_n(core_rst_n), .wr_en(reg_wr), .waddr(reg_waddr),
    .wdata(reg_wdata), .raddr(reg_raddr), .rdata(reg_rdata), .wrap(wrap),
    .ctrl(ctrl), .act_per(act_per), .act_cmp(act_cmp)
  );

  pwm_shadow_counter #(.DATA_W(DATA_W)) u_cnt (
    .clk(clk), .rst_n(core_rst_n), .run(ctrl[BIT_RUN]), .period(act_per),
    .cnt(cnt), .wrap(wrap)
  );

  pwm_shadow_compare #(.DATA_W(DATA_W)) u_cmp (
    .clk(clk), .rst_n(core_rst_n), .cnt(cnt), .cmp(act_cmp),
    .mode(ctrl[BIT_MODE]), .inv(ctrl[BIT_INV]), .pwm(pwm_out)
  );

  // R1
  reset_low_chk: assert property (@(posedge clk)
    !core_rst_n |-> !pwm_out);
endmodule

// File: tb/pwm_shadow_gen_test.sv
module pwm_shadow_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_waddr = 3'd0;
  logic [31:0] reg_wdata = '0;
  logic [2:0]  reg_raddr = 3'd0;
  logic [31:0] reg_rdata;
  logic        pwm_out;

  int checks = 0, fails = 0;
  logic chk_en = 1'b0;

  always #2 clk = ~clk;

  pwm_shadow_gen uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .pwm_out(pwm_out)
  );

  // Requirement-level model
  logic [15:0] m_ctrl;
  logic [31:0] m_cnt, m_per, m_cmp, m_sper, m_scmp;
  logic        m_pend;

  function automatic logic exp_out(input logic [15:0] c, input logic [31:0] n,
                                   input logic [31:0] k);
    if (!c[9]) return 1'b0;
    return (n < k) ^ c[10];
  endfunction

  function automatic logic [31:0] exp_rd(input logic [2:0] a);
    case (a)
      3'd0: return {16'h0, m_ctrl};
      3'd1: return m_per;
      3'd2: return m_cmp;
      3'd3: return m_sper;
      3'd4: return m_scmp;
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl <= '0; m_cnt <= '0; m_per <= '0; m_cmp <= '0;
      m_sper <= '0; m_scmp <= '0; m_pend <= 1'b0;
    end else begin
      logic [31:0] lastc;
      logic run, wrp, xf, sw;
      run   = m_ctrl[4];
      lastc = (m_per == 0) ? 32'd0 : m_per - 1;
      wrp   = run && (m_cnt >= lastc);
      xf    = wrp && m_pend;
      sw    = reg_wr && (reg_waddr == 3'd3 || reg_waddr == 3'd4);
      if (run) m_cnt <= wrp ? 32'd0 : m_cnt + 1;
      if (reg_wr) begin
        case (reg_waddr)
          3'd0: m_ctrl <= reg_wdata[15:0];
          3'd1: if (!run) m_per <= reg_wdata;
          3'd2: if (!run) m_cmp <= reg_wdata;
          3'd3: m_sper <= reg_wdata;
          3'd4: m_scmp <= reg_wdata;
          default: ;
        endcase
      end
      if (xf) begin m_per <= m_sper; m_cmp <= m_scmp; end
      m_pend <= (m_pend && !xf) || sw;
    end
  end

  always @(negedge clk) begin
    if (chk_en) begin
      logic e;
      logic [31:0] r;
      e = exp_out(m_ctrl, m_cnt, m_cmp);
      checks++;
      if (pwm_out !== e) begin
        fails++;
        $display("FAIL R6/R7 pwm_out per-cycle: got %0b expected %0b", pwm_out, e);
      end
      r = exp_rd(reg_raddr);
      checks++;
      if (reg_rdata !== r) begin
        fails++;
        $display("FAIL R2 read addr %0d: got %h expected %h", reg_raddr, reg_rdata, r);
      end
    end
  end

  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_waddr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [31:0] exp, input string tag);
    reg_raddr = a;
    @(negedge clk);
    chk(reg_rdata, exp, tag);
  endtask

  task automatic count_high(input int n, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_out) hi++;
    end
  endtask

  logic done = 1'b0;

  initial begin
    #(4 * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int hi;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 5; a++) rd_chk(a[2:0], 32'h0, "R1 reset register");
    chk({31'h0, pwm_out}, 32'h0, "R1 reset output");
    chk_en = 1'b1;

    // R2 / R3 control storage and truncation
    wr(3'd0, 32'hABCD_00C0);
    rd_chk(3'd0, 32'h0000_00C0, "R3 sync bits stored, R2 upper bits dropped");
    rd_chk(3'd6, 32'h0, "R2 unused address");

    // R9 direct writes while stopped
    wr(3'd1, 32'd10);
    wr(3'd2, 32'd3);
    rd_chk(3'd1, 32'd10, "R9 active period direct write");
    rd_chk(3'd2, 32'd3, "R9 active compare direct write");

    // R10 / R6 start: first cycle after control write has counter 0
    wr(3'd0, 32'h0000_0210);
    count_high(10, hi);
    chk(hi, 3, "R6 high time per period, R10 start timing");

    // R9 active write ignored while running
    wr(3'd1, 32'd99);
    rd_chk(3'd1, 32'd10, "R9 active write ignored while running");

    // R8 on-the-fly shadow change
    wr(3'd3, 32'd6);
    wr(3'd4, 32'd4);
    rd_chk(3'd1, 32'd10, "R8 active period unchanged before boundary");
    repeat (12) @(negedge clk);
    rd_chk(3'd1, 32'd6, "R8 shadow period transferred");
    rd_chk(3'd2, 32'd4, "R8 shadow compare transferred");
    count_high(60, hi);
    chk(hi, 40, "R8 high time after change");

    // R7 polarity flip
    wr(3'd0, 32'h0000_0610);
    count_high(60, hi);
    chk(hi, 20, "R7 inverted high time");

    // R6 compare zero / compare above period
    wr(3'd0, 32'h0000_0200);
    wr(3'd2, 32'd0);
    wr(3'd0, 32'h0000_0210);
    count_high(20, hi);
    chk(hi, 0, "R6 compare zero constant low");
    wr(3'd0, 32'h0000_0200);
    wr(3'd2, 32'd20);
    wr(3'd0, 32'h0000_0210);
    count_high(20, hi);
    chk(hi, 20, "R6 compare above period constant high");

    // R5 period zero acts as one
    wr(3'd0, 32'h0000_0200);
    wr(3'd1, 32'd0);
    wr(3'd2, 32'd1);
    wr(3'd0, 32'h0000_0210);
    count_high(10, hi);
    chk(hi, 10, "R5 period zero behaves as one");

    // R4 counter hold: stop mid-period, output frozen
    wr(3'd0, 32'h0000_0200);
    wr(3'd1, 32'd8);
    wr(3'd2, 32'd4);
    wr(3'd0, 32'h0000_0210);
    repeat (2) @(negedge clk);
    wr(3'd0, 32'h0000_0200);
    count_high(12, hi);
    chk(hi, 12, "R4 counter holds below compare when stopped");

    // R3 mode off forces low
    wr(3'd0, 32'h0000_0010);
    count_high(16, hi);
    chk(hi, 0, "R3 output low with mode off");

    // Random phase, checked every cycle against the model
    for (int i = 0; i < 4000; i++) begin
      @(posedge clk); #1;
      reg_raddr = 3'($urandom_range(0, 7));
      reg_wr = ($urandom_range(0, 5) == 0);
      reg_waddr = 3'($urandom_range(0, 5));
      if (reg_waddr == 3'd0)
        reg_wdata = $urandom & 32'h0000_06D0;
      else if (reg_waddr == 3'd1 || reg_waddr == 3'd3)
        reg_wdata = $urandom_range(0, 15);
      else
        reg_wdata = $urandom_range(0, 18);
    end
    @(posedge clk); #1;
    reg_wr = 1'b0;
    repeat (4) @(negedge clk);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule